// File: doc/BRIEF.md
# Four-Channel Operating-System Match Timer

This block is the system tick source for an operating system. A 32-bit up-counter advances by one on each cycle where the tick-enable input is high. The tick-enable comes from an external divider, so the tick rate is set at system level. Nominal rates are 3.6864 MHz or 3.25 MHz. Four channels each hold a match value. When the counter steps onto a channel's match value and that channel is enabled, the channel latches a sticky status bit and raises its own interrupt line. The line stays high until software clears the bit with a write-one-to-clear access.

Channel 3 can also act as a watchdog. While a one-shot arm bit is set, a channel-3 match pulses a reset-request output for one cycle and disarms itself. Software uses a plain 32-bit register port to read and write the match values, the counter, the status bits, the interrupt enables and the watchdog arm bit. Reads return data one cycle after the request.

Top module: `os_match_timer`

## Requirements
- R1: After a synchronous reset, all registers read zero, and `irq` and `wdog_rst_req` are low.
- R2: A write to the counter (offset 0x10) loads it. From then on, it increases by one on each cycle with `tick_en` high. A counter write in the same cycle as a tick takes priority over the increment.
- R3: Consider a channel whose enable bit (bit i of the enable register, offset 0x1C) is set. On the clock edge where a tick moves the counter onto that channel's match value, the channel's status bit (bit i of offset 0x14) is set and `irq[i]` goes high. Match values for channel i sit at offset 4*i.
- R4: If the channel's enable bit is clear, the same match changes neither its status bit nor its interrupt line. Loading the counter by a write never produces a match.
- R5: A write to the status register clears each bit written as 1 and lowers the matching `irq` line. Bits written as 0 keep their value. A match in the same cycle as a clear leaves the bit set.
- R6: The enable register keeps only bits 11:0. The upper bits read back as zero.
- R7: Suppose bit 0 of the watchdog register (offset 0x18) is set. A channel-3 match then drives `wdog_rst_req` high for exactly one cycle and clears that bit. This happens regardless of the channel-3 enable. When the bit is clear, no request is made.
- R8: A read returns, one cycle after `rd_en`, the value of the addressed register on `rdata`.
- R9: A read of any other offset, including any offset that is not word aligned, returns zero and raises `rd_err` for one cycle. A write to such an offset changes no register.
- R10: The counter wraps from 0xFFFFFFFF to 0. A match value of 0 is reached by that wrap.
- R11: A status bit, and its interrupt line, stays set through further ticks until it is cleared by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one cycle after `rd_en` |
| rd_err | output | 1 | One-cycle flag for a read of an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong counter value shows up through a counter read. It also shows up as a channel that fires on the wrong tick, or never fires. Since `irq` is driven straight from the status flops, a wrong enable or status bit appears on the interrupt pins on the very edge where the match should take effect. The bench compares them at that cycle. A stuck or lingering watchdog arm bit shows as a missing or repeated reset pulse on the first channel-3 match. It also shows in the value read back from the watchdog register at the next read.

// File: rtl/otmr_pkg.sv
package otmr_pkg;
  localparam int NUM_CH      = 4;
  localparam int WDOG_CH     = 3;
  localparam int IEN_BITS    = 12;
  localparam int OFS_COUNT   = 'h10;
  localparam int OFS_STATUS  = 'h14;
  localparam int OFS_WDOG    = 'h18;
  localparam int OFS_IEN     = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MATCH, SEL_COUNT, SEL_STATUS, SEL_WDOG, SEL_IEN
  } reg_sel_e;
endpackage

// File: rtl/otmr_counter.sv
module otmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_inc,
  output logic         step
);
  assign step    = tick & ~load;
  assign cnt_inc = cnt + {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_inc;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt == $past(cnt_inc));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/otmr_channel.sv
module otmr_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         match_we,
  input  logic [W-1:0] wdata,
  input  logic         step,
  input  logic [W-1:0] cnt_inc,
  input  logic         ien,
  input  logic         clr,
  output logic [W-1:0] match_val,
  output logic         hit,
  output logic         status
);
  assign hit = step && (cnt_inc == match_val);

  always_ff @(posedge clk) begin
    if (rst)           match_val <= '0;
    else if (match_we) match_val <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 1'b0;
    else     status <= (status & ~clr) | (hit & ien);
  end

  assert_set_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status) |-> $past(ien && step));
  assert_hold_until_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(status) |-> $past(clr));
endmodule

// File: rtl/otmr_wdog.sv
module otmr_wdog (
  input  logic clk,
  input  logic rst,
  input  logic arm_we,
  input  logic arm_bit,
  input  logic hit,
  output logic armed,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      req   <= 1'b0;
    end else if (hit && armed) begin
      armed <= 1'b0;
      req   <= 1'b1;
    end else begin
      req <= 1'b0;
      if (arm_we) armed <= arm_bit;
    end
  end

  assert_req_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  assert_req_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    req |-> (!armed && $past(armed)));
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_err,
  output logic [3:0]        irq,
  output logic              wdog_rst_req
);
  import otmr_pkg::*;

  localparam int CH_IDX_W = $clog2(NUM_CH);

  reg_sel_e              sel;
  logic [CH_IDX_W-1:0]   ch_idx;
  logic [DATA_W-1:0]     cnt, cnt_inc;
  logic                  step;
  logic [NUM_CH-1:0]     hit, status;
  logic [DATA_W-1:0]     match_val [NUM_CH];
  logic [IEN_BITS-1:0]   ien_q;
  logic                  armed;
  logic [DATA_W-1:0]     rd_val;

  always_comb begin
    sel    = SEL_NONE;
    ch_idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (int'(addr) < 4*NUM_CH) begin
        sel    = SEL_MATCH;
        ch_idx = addr[CH_IDX_W+1:2];
      end else if (int'(addr) == OFS_COUNT)  sel = SEL_COUNT;
      else if (int'(addr) == OFS_STATUS)     sel = SEL_STATUS;
      else if (int'(addr) == OFS_WDOG)       sel = SEL_WDOG;
      else if (int'(addr) == OFS_IEN)        sel = SEL_IEN;
    end
  end

  otmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en),
    .load(wr_en && sel == SEL_COUNT), .load_val(wdata),
    .cnt(cnt), .cnt_inc(cnt_inc), .step(step)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    otmr_channel #(.W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .match_we(wr_en && sel == SEL_MATCH && ch_idx == CH_IDX_W'(i)),
      .wdata(wdata), .step(step), .cnt_inc(cnt_inc),
      .ien(ien_q[i]),
      .clr(wr_en && sel == SEL_STATUS && wdata[i]),
      .match_val(match_val[i]), .hit(hit[i]), .status(status[i])
    );
  end

  otmr_wdog u_wdog (
    .clk(clk), .rst(rst),
    .arm_we(wr_en && sel == SEL_WDOG), .arm_bit(wdata[0]),
    .hit(hit[WDOG_CH]), .armed(armed), .req(wdog_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst)                            ien_q <= '0;
    else if (wr_en && sel == SEL_IEN)   ien_q <= wdata[IEN_BITS-1:0];
  end

  assign irq = status;

  always_comb begin
    case (sel)
      SEL_MATCH:  rd_val = match_val[ch_idx];
      SEL_COUNT:  rd_val = cnt;
      SEL_STATUS: rd_val = DATA_W'(status);
      SEL_WDOG:   rd_val = DATA_W'(armed);
      SEL_IEN:    rd_val = DATA_W'(ien_q);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= rd_en && sel == SEL_NONE;
      if (rd_en) rdata <= rd_val;
    end
  end

  assert_err_only_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> ($past(rd_en) && rdata == '0));
  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq[0]) |-> $past(ien_q[0])));
endmodule

// File: tb/sim_os_match_timer.sv
module sim_os_match_timer;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick_en = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_err;
  logic [3:0]  irq;
  logic        wdog_rst_req;
  int checks = 0, errors = 0;
  logic [31:0] rv;
  logic        re;

  always #5 clk = ~clk;

  os_match_timer u0 (.clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rd_err(rd_err),
    .irq(irq), .wdog_rst_req(wdog_rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; d = rdata; e = rd_err;
  endtask

  task automatic tick(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {28'b0, irq}, 0);
    chk("R1 req", {31'b0, wdog_rst_req}, 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a), rv, re);
      chk("R1 reg", rv, 0);
    end

    // R6 enable keeps 12 bits; R8 readback
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, rv, re); chk("R6 ien", rv, 32'h0000_0FFF);
    wr(8'h0C, 32'hDEAD_BEEF); rd(8'h0C, rv, re); chk("R8 match3", rv, 32'hDEAD_BEEF);

    // R2 load and count
    wr(8'h10, 32'h0000_1000); tick(7); rd(8'h10, rv, re); chk("R2 count", rv, 32'h1007);
    // R2 load wins over tick
    tick_en = 1; wr(8'h10, 32'h55); tick_en = 0;
    rd(8'h10, rv, re); chk("R2 load priority", rv, 32'h55);

    // R3/R4/R5/R11 sweep over all enable masks
    for (int m = 0; m < 16; m++) begin
      logic [31:0] b;
      b = 32'h100 * (m + 1);
      wr(8'h1C, 32'(m));
      for (int i = 0; i < 4; i++) wr(8'(4*i), b + 3 + 2*i);
      wr(8'h10, b);
      wr(8'h14, 32'hF);
      chk("R4 no match on load", {28'b0, irq}, 0);
      for (int t = 1; t <= 10; t++) begin
        logic [3:0] e;
        tick(1);
        for (int i = 0; i < 4; i++) e[i] = m[i] && (t >= 3 + 2*i);
        chk("R3 R4 progressive irq", {28'b0, irq}, {28'b0, e});
      end
      rd(8'h14, rv, re); chk("R3 status read", rv, 32'(m));
      tick(4);
      chk("R11 irq held", {28'b0, irq}, 32'(m));
      wr(8'h14, 32'h5);
      chk("R5 partial clear", {28'b0, irq}, 32'(m & 4'hA));
      wr(8'h14, 32'hF);
      tick(3);
      chk("R3 no rematch", {28'b0, irq}, 0);
    end

    // R5 set wins over clear in same cycle
    wr(8'h1C, 32'h2); wr(8'h04, 32'h40); wr(8'h10, 32'h3F);
    tick_en = 1; wr(8'h14, 32'h2); tick_en = 0;
    chk("R5 set beats clear", {28'b0, irq}, 32'h2);
    wr(8'h14, 32'hF);

    // R10 wrap
    wr(8'h1C, 32'h1); wr(8'h00, 32'h0); wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    chk("R10 wrap irq", {28'b0, irq}, 32'h1);
    rd(8'h10, rv, re); chk("R10 wrap count", rv, 0);
    wr(8'h14, 32'hF);

    // R7 watchdog
    wr(8'h1C, 32'h0); wr(8'h0C, 32'h202); wr(8'h18, 32'h1); wr(8'h10, 32'h200);
    tick(1); chk("R7 no early req", {31'b0, wdog_rst_req}, 0);
    tick(1); chk("R7 req pulse", {31'b0, wdog_rst_req}, 1);
    chk("R7 irq off when disabled", {28'b0, irq}, 0);
    @(negedge clk); chk("R7 req one cycle", {31'b0, wdog_rst_req}, 0);
    rd(8'h18, rv, re); chk("R7 arm cleared", rv, 0);
    wr(8'h10, 32'h200); tick(2);
    chk("R7 disarmed no req", {31'b0, wdog_rst_req}, 0);

    // R9 unmapped
    rd(8'h20, rv, re); chk("R9 data", rv, 0); chk("R9 err", {31'b0, re}, 1);
    @(negedge clk); chk("R9 err one cycle", {31'b0, rd_err}, 0);
    rd(8'h02, rv, re); chk("R9 unaligned err", {31'b0, re}, 1);
    wr(8'h01, 32'h1234); rd(8'h00, rv, re); chk("R9 write ignored", rv, 0);
    chk("R9 good read no err", {31'b0, re}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule